// File: doc/BRIEF.md
# Programmable-Frequency Synchronous PWM Generator

This block turns a digital on-time command into the two gate-enable signals of a synchronous buck power stage: a high-side enable that connects the inductor to the supply and a low-side enable that clamps the switching node to ground. A 4-bit code picks one of sixteen switching periods, from 1 MHz at code 0 down to 200 kHz at code 15, in equal frequency steps. A strobe marks the first clock of every switching cycle so that downstream sampling logic can lock to it.

The duty word gives the high-side on-window in clock cycles. Each cycle the window is clamped to keep a minimum off time. A zero or very short window yields no high-side pulse at all, which is how pulses are skipped. A peak-current-limit flag cuts the high-side pulse short for the rest of the cycle. A zero-current flag from the low-side switch releases the low side for the rest of the cycle, for light-load operation. A fixed dead time keeps the two legs apart in both directions. When the block is disabled both enables sit low and the cycle counter is held at its start.

Top module: `pwm_sync_gen`

## Requirements
- R1: The switching period in clocks for code c (0..15) is round(CLK_HZ / f) with f = 1 MHz - c x 800 kHz / 15; with the default 50 MHz clock, code 0 gives 50 clocks, code 7 gives 80 and code 15 gives 250.
- R2: The frequency code and the duty word are sampled only on the first clock of a cycle; changing either mid-cycle leaves the current cycle's period and pulse unchanged.
- R3: The on-window is min(duty, period - MIN_OFF), where MIN_OFF = ceil(150 ns x CLK_HZ) clocks (8 at 50 MHz). In steady state the high-side enable is high for on-window - DEAD_CLKS clocks and the low-side enable for period - on-window - DEAD_CLKS clocks, so the high side is off for at least MIN_OFF clocks per cycle.
- R4: An on-window of DEAD_CLKS clocks or less (including a duty word of 0) produces no high-side pulse in that cycle.
- R5: A current-limit flag sampled while the high side is meant to conduct ends the high-side pulse for the rest of that cycle; the next cycle starts a full pulse.
- R6: A zero-current flag sampled while the high side is not meant to conduct turns the low-side enable off for the rest of the cycle; during the on-window the flag is ignored.
- R7: The two enables are never high together, and each rises only after the other has been low for at least DEAD_CLKS clock samples.
- R8: After reset and while enable is low, both enables and the strobe are low; the first strobe appears one clock after enable is sampled high.
- R9: The cycle-start strobe is high for exactly one clock per period, coinciding with the first clock of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low holds both legs off and the counter at zero |
| freq_code_i | input | 4 | Switching-frequency select, 0 = 1 MHz, 15 = 200 kHz |
| duty_i | input | DUTY_W (8) | Requested high-side on-window in clocks |
| ilim_i | input | 1 | Peak-current-limit flag |
| zc_i | input | 1 | Low-side zero-current flag |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| cyc_start_o | output | 1 | One-clock strobe at the start of each switching cycle |

## Verification
The pulse pattern is tried at several frequency codes with a mid-range duty, with an oversized duty, with duties of zero and of the dead time, and with a code change arriving halfway through a cycle. Period measurements separate a wrong table entry from a code sampled at the wrong moment. Pulse widths separate a missing clamp from missing dead time, and the skip cases show whether short windows leak a runt pulse. Single-clock current-limit and zero-current pulses placed inside and outside the on-window show whether each flag cuts only its own leg, only in its own phase, and only for one cycle.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    // Switching period in clocks for one frequency code; the frequency is
    // kept in units of kHz/15 so the step of 800/15 kHz stays integral.
    function automatic int period_clks(input int code, input longint clk_hz);
        longint f15;
        f15 = 64'd15000 - 64'd800 * longint'(code);
        return int'((clk_hz * 15 + f15 * 500) / (f15 * 1000));
    endfunction

    // Smallest whole number of clocks covering a time span in ns.
    function automatic int ns_to_clks(input longint clk_hz, input int ns);
        return int'((clk_hz * longint'(ns) + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/pwm_period_lut.sv
module pwm_period_lut
    import pwm_sync_pkg::*;
#(
    parameter longint CLK_HZ = 50_000_000,
    parameter int     CODE_W = 4,
    parameter int     CNT_W  = 8
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  per_o
);
    localparam int N_CODES = 1 << CODE_W;

    logic [CNT_W-1:0] tbl [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_entry
        assign tbl[g] = CNT_W'(period_clks(g, CLK_HZ));
    end

    assign per_o = tbl[code_i];
endmodule

// File: rtl/pwm_on_clamp.sv
module pwm_on_clamp #(
    parameter int CNT_W   = 8,
    parameter int DUTY_W  = 8,
    parameter int MIN_OFF = 8
) (
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [CNT_W-1:0]  per_i,
    output logic [CNT_W-1:0]  on_o
);
    localparam int CW = (DUTY_W > CNT_W) ? DUTY_W + 1 : CNT_W + 1;

    logic [CW-1:0] limit;
    logic [CW-1:0] duty_x;

    always_comb begin
        limit  = CW'(per_i) - CW'(MIN_OFF);
        duty_x = CW'(duty_i);
        on_o   = (duty_x > limit) ? CNT_W'(limit) : CNT_W'(duty_x);
    end
endmodule

// File: rtl/pwm_sync_gen.sv
module pwm_sync_gen
    import pwm_sync_pkg::*;
#(
    parameter longint CLK_HZ     = 50_000_000,
    parameter int     DUTY_W     = 8,
    parameter int     MIN_OFF_NS = 150,
    parameter int     DEAD_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [3:0]        freq_code_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              ilim_i,
    input  logic              zc_i,
    output logic              hs_en_o,
    output logic              ls_en_o,
    output logic              cyc_start_o
);
    localparam int MAX_PER = period_clks(15, CLK_HZ);
    localparam int CNT_W   = $clog2(MAX_PER + 1);
    localparam int MIN_OFF = ns_to_clks(CLK_HZ, MIN_OFF_NS);
    localparam int DW      = $clog2(DEAD_CLKS + 1);
    localparam logic [DW-1:0] DLIM = DW'(DEAD_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] on;
        logic             cut;
        logic             zc_seen;
        logic             hs;
        logic             ls;
        logic             start;
        logic [DW-1:0]    hs_low;
        logic [DW-1:0]    ls_low;
    } st_t;

    st_t q, d;

    logic [CNT_W-1:0] lut_per;
    logic [CNT_W-1:0] clamp_on;

    pwm_period_lut #(.CLK_HZ(CLK_HZ), .CODE_W(4), .CNT_W(CNT_W)) i_lut (
        .code_i (freq_code_i),
        .per_o  (lut_per)
    );

    pwm_on_clamp #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .MIN_OFF(MIN_OFF)) i_clamp (
        .duty_i (duty_i),
        .per_i  (lut_per),
        .on_o   (clamp_on)
    );

    logic             at_start;
    logic [CNT_W-1:0] cur_per;
    logic [CNT_W-1:0] cur_on;
    logic             in_on;
    logic             cut_now;
    logic             hs_want;
    logic             zc_now;
    logic             ls_want;

    always_comb begin
        d        = q;
        at_start = (q.cnt == '0);
        cur_per  = at_start ? lut_per  : q.per;
        cur_on   = at_start ? clamp_on : q.on;
        in_on    = (q.cnt < cur_on);
        cut_now  = (at_start ? 1'b0 : q.cut) | (ilim_i & in_on);
        hs_want  = in_on & ~cut_now;
        zc_now   = (at_start ? 1'b0 : q.zc_seen) | (zc_i & ~hs_want);
        ls_want  = ~hs_want & ~zc_now;

        // Count samples each leg has been low, saturating at the dead time.
        d.hs_low = q.hs ? '0 : ((q.hs_low == DLIM) ? DLIM : q.hs_low + 1'b1);
        d.ls_low = q.ls ? '0 : ((q.ls_low == DLIM) ? DLIM : q.ls_low + 1'b1);

        if (!enable_i) begin
            d.cnt     = '0;
            d.cut     = 1'b0;
            d.zc_seen = 1'b0;
            d.hs      = 1'b0;
            d.ls      = 1'b0;
            d.start   = 1'b0;
        end else begin
            d.cnt     = (q.cnt == cur_per - 1'b1) ? '0 : q.cnt + 1'b1;
            d.per     = cur_per;
            d.on      = cur_on;
            d.cut     = cut_now;
            d.zc_seen = zc_now;
            d.hs      = hs_want & ~q.ls & (q.ls_low >= DLIM);
            d.ls      = ls_want & ~q.hs & (q.hs_low >= DLIM);
            d.start   = at_start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.hs_low <= DLIM;
            q.ls_low <= DLIM;
        end else begin
            q <= d;
        end
    end

    assign hs_en_o     = q.hs;
    assign ls_en_o     = q.ls;
    assign cyc_start_o = q.start;
endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic ilim_i,
    input logic zc_i,
    input logic hs_en_o,
    input logic ls_en_o,
    input logic cyc_start_o
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en_o && ls_en_o)); // R7

    AST_LS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en_o) |-> !$past(hs_en_o)); // R7

    AST_HS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en_o) |-> !$past(ls_en_o)); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!hs_en_o && !ls_en_o && !cyc_start_o)); // R8

    AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en_o && ilim_i) |=> !hs_en_o); // R5

    AST_ZC_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en_o && zc_i) |=> !ls_en_o); // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |=> !cyc_start_o); // R9
endmodule

bind pwm_sync_gen pwm_sync_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .ilim_i      (ilim_i),
    .zc_i        (zc_i),
    .hs_en_o     (hs_en_o),
    .ls_en_o     (ls_en_o),
    .cyc_start_o (cyc_start_o)
);

// File: tb/test_pwm_sync_gen.sv
`timescale 1ns/1ps
module test_pwm_sync_gen;
    localparam longint CLK_HZ = 50_000_000;
    localparam int DUTY_W = 8;
    localparam int MOFF_NS = 150;
    localparam int DEAD = 2;
    localparam int MOFF = (MOFF_NS * 50 + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0;
    logic [3:0] freq_code_i = '0;
    logic [DUTY_W-1:0] duty_i = '0;
    logic ilim_i = 1'b0;
    logic zc_i = 1'b0;
    logic hs_en_o, ls_en_o, cyc_start_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwm_sync_gen #(.CLK_HZ(CLK_HZ), .DUTY_W(DUTY_W), .MIN_OFF_NS(MOFF_NS),
                   .DEAD_CLKS(DEAD)) i_pwm_sync_gen (.*);

    function automatic int ref_period(input int code);
        real f;
        f = 1.0e6 - real'(code) * 800.0e3 / 15.0;
        return $rtoi(50.0e6 / f + 0.5);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    // Behavioural reference: tracks position in the cycle and the legs.
    int m_pos, m_len, m_on, m_cut, m_zc, m_hs, m_ls, m_st, m_hlow, m_llow;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = 0; m_len = 0; m_on = 0; m_cut = 0; m_zc = 0;
            m_hs = 0; m_ls = 0; m_st = 0; m_hlow = DEAD - 1; m_llow = DEAD - 1;
        end else begin
            int nh, nl, len, onl, fresh, inon, want_h, want_l;
            fresh = (m_pos == 0);
            len = fresh ? ref_period(freq_code_i) : m_len;
            onl = fresh ? ((int'(duty_i) > len - MOFF) ? len - MOFF : int'(duty_i)) : m_on;
            inon = (m_pos < onl);
            if (fresh) begin m_cut = 0; m_zc = 0; end
            if (ilim_i && inon) m_cut = 1;
            want_h = inon && !m_cut;
            if (zc_i && !want_h) m_zc = 1;
            want_l = !want_h && !m_zc;
            nh = want_h && !m_ls && (m_llow >= DEAD - 1);
            nl = want_l && !m_hs && (m_hlow >= DEAD - 1);
            m_hlow = m_hs ? 0 : ((m_hlow + 1 > DEAD - 1) ? DEAD - 1 : m_hlow + 1);
            m_llow = m_ls ? 0 : ((m_llow + 1 > DEAD - 1) ? DEAD - 1 : m_llow + 1);
            if (!enable_i) begin
                m_pos = 0; m_cut = 0; m_zc = 0; m_hs = 0; m_ls = 0; m_st = 0;
            end else begin
                m_st = fresh; m_len = len; m_on = onl;
                m_hs = nh; m_ls = nl;
                m_pos = (m_pos == len - 1) ? 0 : m_pos + 1;
            end
        end
    end

    int overlap = 0;
    int dbl_strobe = 0;
    bit prev_st = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(hs_en_o == m_hs[0], "R3 model hs_en", int'(hs_en_o), m_hs);
            check(ls_en_o == m_ls[0], "R6 model ls_en", int'(ls_en_o), m_ls);
            check(cyc_start_o == m_st[0], "R9 model strobe", int'(cyc_start_o), m_st);
            if (hs_en_o && ls_en_o) overlap++;
            if (prev_st && cyc_start_o) dbl_strobe++;
            prev_st = cyc_start_o;
        end
    end

    // kind: 0 none, 1 ilim pulse, 2 zc pulse, 3 code -> 15
    task automatic measure(input int kind, input int k, output int per,
                           output int hw, output int lw);
        int i;
        @(negedge clk);
        while (!cyc_start_o) @(negedge clk);
        i = 0; hw = 0; lw = 0;
        do begin
            hw += int'(hs_en_o);
            lw += int'(ls_en_o);
            if (i == k) begin
                if (kind == 1) ilim_i = 1'b1;
                if (kind == 2) zc_i = 1'b1;
                if (kind == 3) freq_code_i = 4'd15;
            end
            if (i == k + 1) begin ilim_i = 1'b0; zc_i = 1'b0; end
            @(negedge clk);
            i++;
        end while (!cyc_start_o);
        per = i;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired act=0 exp=1");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int p, h, l;
        repeat (5) @(negedge clk);
        check(!hs_en_o && !ls_en_o && !cyc_start_o, "R8 reset outputs",
              int'({hs_en_o, ls_en_o, cyc_start_o}), 0);
        rst_n = 1'b1;
        duty_i = 8'd20; freq_code_i = 4'd0;
        @(negedge clk);
        enable_i = 1'b1;
        @(negedge clk);
        check(cyc_start_o == 1'b1, "R8 first strobe after enable", int'(cyc_start_o), 1);
        measure(0, -5, p, h, l);
        measure(0, -5, p, h, l);
        check(p == ref_period(0), "R1 period code 0", p, ref_period(0));
        check(h == 20 - DEAD, "R3 hs width duty 20", h, 20 - DEAD);
        check(l == p - 20 - DEAD, "R3 ls width duty 20", l, p - 20 - DEAD);

        freq_code_i = 4'd7;
        measure(0, -5, p, h, l);
        measure(0, -5, p, h, l);
        check(p == ref_period(7), "R1 period code 7", p, ref_period(7));

        freq_code_i = 4'd15;
        measure(0, -5, p, h, l);
        measure(0, -5, p, h, l);
        check(p == ref_period(15), "R1 period code 15", p, ref_period(15));

        freq_code_i = 4'd0; duty_i = 8'd255;
        measure(0, -5, p, h, l);
        measure(0, -5, p, h, l);
        check(h == p - MOFF - DEAD, "R3 clamped hs width", h, p - MOFF - DEAD);
        check(p - h >= MOFF, "R3 min off kept", p - h, MOFF);

        duty_i = 8'd0;
        measure(0, -5, p, h, l);
        measure(0, -5, p, h, l);
        check(h == 0, "R4 duty 0 skips", h, 0);
        check(l == p, "R4 duty 0 low side full", l, p);
        duty_i = 8'(DEAD);
        measure(0, -5, p, h, l);
        measure(0, -5, p, h, l);
        check(h == 0, "R4 duty at dead time skips", h, 0);

        duty_i = 8'd30;
        measure(0, -5, p, h, l);
        measure(1, 10, p, h, l);
        check(h == 9, "R5 ilim truncates hs", h, 9);
        measure(0, -5, p, h, l);
        check(h == 30 - DEAD, "R5 next cycle full", h, 30 - DEAD);

        duty_i = 8'd20;
        measure(0, -5, p, h, l);
        measure(2, 30, p, h, l);
        check(l == 30 + 1 - 20 - DEAD, "R6 zc cuts ls", l, 30 + 1 - 20 - DEAD);
        measure(2, 5, p, h, l);
        check(l == p - 20 - DEAD, "R6 zc ignored in on window", l, p - 20 - DEAD);
        check(h == 20 - DEAD, "R6 zc in on window leaves hs", h, 20 - DEAD);

        measure(3, 5, p, h, l);
        check(p == ref_period(0), "R2 mid-cycle code change deferred", p, ref_period(0));
        measure(0, -5, p, h, l);
        check(p == ref_period(15), "R2 new code next cycle", p, ref_period(15));

        enable_i = 1'b0;
        @(negedge clk);
        begin
            int act = 0;
            repeat (300) begin
                @(negedge clk);
                act += int'(hs_en_o) + int'(ls_en_o) + int'(cyc_start_o);
            end
            check(act == 0, "R8 disabled outputs low", act, 0);
        end
        freq_code_i = 4'd0;
        enable_i = 1'b1;
        @(negedge clk);
        check(cyc_start_o == 1'b1, "R8 restart strobe", int'(cyc_start_o), 1);
        measure(0, -5, p, h, l);

        check(overlap == 0, "R7 legs never overlap", overlap, 0);
        check(dbl_strobe == 0, "R9 strobe single clock", dbl_strobe, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule